// File: doc/BRIEF.md
# Low-Power-Aware Watchdog Timer

This block is a watchdog counter for a small controller-style subsystem. Software arms and services it with a two-write key sequence. The counter then advances on every system clock. If it reaches the tap picked by a 3-bit duration code, the block pulls a reset output high for a fixed number of cycles. After that pulse the watchdog returns to the disarmed state.

The block follows the system's power modes. In power-down the counting clock is treated as stopped, so the count freezes. A hardware reset, including one used to leave power-down, disarms the watchdog. When the system leaves power-down through a low-level external interrupt, counting stays held for as long as that line is low. It resumes only once the line returns high, so a long wake pulse cannot cause a spurious bite. Idle mode does not affect counting.

Top module: `pm_watchdog`

## Requirements
- R1: After a synchronous hardware reset `rst`, the block is in this state: `dur_rdata` reads 0x00 (duration code 000), `wd_armed` is 0 and `wd_reset` is 0.
- R2: A write on `dur_wr` loads `dur_wdata[2:0]` into the duration code. `dur_rdata[2:0]` returns the stored code and `dur_rdata[7:3]` always reads 0, whatever was written to those bits.
- R3: While armed, `wd_reset` rises 2^(TAP_BASE + code) counting cycles after the clock edge that accepts the completing service write. The default TAP_BASE is 14, so taps run from 2^14 (code 000) to 2^21 (code 111) cycles.
- R4: The service sequence is a write of 0x1E on `svc_wr`, followed by a write of 0xE1 with no other `svc_wr` write between them. Cycles without a write may fall between the two writes. Completing the sequence arms the watchdog and clears the count to zero.
- R5: A write of any other value between 0x1E and 0xE1 aborts the sequence. A 0xE1 write with no 0x1E before it has no effect: the watchdog stays disarmed, or keeps its running count.
- R6: The `wd_reset` pulse lasts exactly BITE_CYCLES cycles (default 96). After the pulse, `wd_armed` is 0 and the watchdog stays disarmed until a new service sequence arms it.
- R7: Software cannot disarm the watchdog. Once armed, no `svc_wr` or `dur_wr` write clears `wd_armed`. Only `rst` or a completed bite clears it.
- R8: While `pd_mode` is 1, the count holds its value, so power-down time does not count toward the timeout.
- R9: `idle_mode` has no effect on counting: a timeout in idle takes as many cycles as one outside idle.
- R10: Entering power-down arms a wake hold. After `pd_mode` falls, counting stays held on every cycle in which `wake_n` is 0. Counting resumes on the first cycle in which `wake_n` is 1.
- R11: A hardware reset applied while in power-down leaves the watchdog disarmed and clears the wake hold. No bite follows.
- R12: `svc_wr` writes made while `wd_reset` is high are ignored: they neither shorten nor extend the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| dur_wr | input | 1 | Write strobe for the duration register |
| dur_wdata | input | 8 | Duration register write data; bits 2:0 hold the code |
| dur_rdata | output | 8 | Duration register read value |
| svc_wr | input | 1 | Write strobe for the service key register |
| svc_wdata | input | 8 | Service key value |
| pd_mode | input | 1 | Power-down mode indication |
| idle_mode | input | 1 | Idle mode indication |
| wake_n | input | 1 | Active-low level wake interrupt line |
| wd_armed | output | 1 | Watchdog armed and counting toward a timeout |
| wd_reset | output | 1 | Watchdog reset pulse |

## Verification
The hardest situation to reach from the ports is a wake that leaves power-down while the interrupt line is still low. Here the count must stay frozen through two distinct phases, first under `pd_mode` and then under the wake hold, and then resume without losing or gaining a cycle. The stimulus arms the watchdog and spends some counting cycles. It then raises `pd_mode` with `wake_n` low, drops `pd_mode` while keeping `wake_n` low for a few more cycles, and finally releases the line. The bench predicts the bite edge by subtracting only the cycles that actually counted, and checks the output one cycle before and at that edge.

// File: rtl/pmwd_pkg.sv
package pmwd_pkg;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_BITE = 2'd2
    } wd_state_e;

    localparam int          SEL_W     = 3;
    localparam int          SEL_SPAN  = (1 << SEL_W) - 1;
    localparam logic [7:0]  KEY_ARM   = 8'h1E;
    localparam logic [7:0]  KEY_FIRE  = 8'hE1;

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
    } key_write_t;

    // Right shift applied to an all-ones count to obtain the last count value
    // of the selected tap: code 0 yields the shortest window.
    function automatic int unsigned tap_drop(logic [SEL_W-1:0] sel);
        return SEL_SPAN - int'(sel);
    endfunction

endpackage

// File: rtl/pmwd_key_seq.sv
module pmwd_key_seq
    import pmwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  key_write_t kw,
    input  logic       block,
    output logic       fire
);

    logic stage_q;

    assign fire = kw.wr && !block && stage_q && (kw.data == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= 1'b0;
        end else if (kw.wr && !block) begin
            stage_q <= (kw.data == KEY_ARM);
        end
    end

    // Any accepted write other than the first key leaves the sequence idle.
    assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (kw.wr && !block && kw.data != KEY_ARM) |=> !stage_q);

    // A completed sequence never leaves a half-open stage behind.
    assert_fire_clears_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> !stage_q);

endmodule

// File: rtl/pmwd_wake_hold.sv
module pmwd_wake_hold (
    input  logic clk,
    input  logic rst,
    input  logic pd_mode,
    input  logic wake_n,
    output logic gate
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (pd_mode) begin
            hold_q <= 1'b1;
        end else if (wake_n) begin
            hold_q <= 1'b0;
        end
    end

    assign gate = pd_mode || (hold_q && !wake_n);

    assert_hold_arm_R10: assert property (@(posedge clk) disable iff (rst)
        pd_mode |=> hold_q);

    assert_hold_release_R10: assert property (@(posedge clk) disable iff (rst)
        (!pd_mode && wake_n) |=> !hold_q);

endmodule

// File: rtl/pmwd_core.sv
module pmwd_core
    import pmwd_pkg::*;
#(
    parameter int TAP_BASE    = 14,
    parameter int BITE_CYCLES = 96
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             gate,
    input  logic [SEL_W-1:0] sel,
    output wd_state_e        state_o
);

    localparam int CNT_W = TAP_BASE + SEL_SPAN;
    localparam int BW    = $clog2(BITE_CYCLES + 1);
    localparam logic [BW-1:0] BITE_LAST = BW'(BITE_CYCLES - 1);

    wd_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [BW-1:0]    bcnt_q;
    logic [CNT_W-1:0] last_c;

    assign last_c  = {CNT_W{1'b1}} >> tap_drop(sel);
    assign state_o = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
            bcnt_q  <= '0;
        end else begin
            unique case (state_q)
                WD_OFF: begin
                    if (fire) begin
                        state_q <= WD_RUN;
                        cnt_q   <= '0;
                    end
                end
                WD_RUN: begin
                    if (fire) begin
                        cnt_q <= '0;
                    end else if (!gate) begin
                        if (cnt_q >= last_c) begin
                            state_q <= WD_BITE;
                            cnt_q   <= '0;
                            bcnt_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                WD_BITE: begin
                    if (bcnt_q == BITE_LAST) begin
                        state_q <= WD_OFF;
                        bcnt_q  <= '0;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                default: state_q <= WD_OFF;
            endcase
        end
    end

    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_RUN && gate && !fire) |=> $stable(cnt_q));

    assert_bite_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_BITE && bcnt_q != BITE_LAST) |=> state_q == WD_BITE);

    assert_no_sw_off_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == WD_RUN) |=> state_q != WD_OFF);

    assert_service_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (fire && state_q != WD_BITE) |=> (cnt_q == '0 && state_q == WD_RUN));

endmodule

// File: rtl/pm_watchdog.sv
module pm_watchdog
    import pmwd_pkg::*;
#(
    parameter int TAP_BASE    = 14,
    parameter int BITE_CYCLES = 96
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dur_wr,
    input  logic [7:0] dur_wdata,
    output logic [7:0] dur_rdata,
    input  logic       svc_wr,
    input  logic [7:0] svc_wdata,
    input  logic       pd_mode,
    input  logic       idle_mode,
    input  logic       wake_n,
    output logic       wd_armed,
    output logic       wd_reset
);

    logic [SEL_W-1:0] sel_q;
    key_write_t       kw;
    logic             fire;
    logic             gate;
    wd_state_e        state;
    logic             unused_sink;

    // Idle keeps the clock running, so it plays no part in counting;
    // reserved register bits are not stored.
    assign unused_sink = ^{idle_mode, dur_wdata[7:SEL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (dur_wr) begin
            sel_q <= dur_wdata[SEL_W-1:0];
        end
    end

    assign dur_rdata = {{(8 - SEL_W){1'b0}}, sel_q};
    assign kw        = '{wr: svc_wr, data: svc_wdata};

    pmwd_key_seq u_key (
        .clk   (clk),
        .rst   (rst),
        .kw    (kw),
        .block (state == WD_BITE),
        .fire  (fire)
    );

    pmwd_wake_hold u_wake (
        .clk     (clk),
        .rst     (rst),
        .pd_mode (pd_mode),
        .wake_n  (wake_n),
        .gate    (gate)
    );

    pmwd_core #(
        .TAP_BASE    (TAP_BASE),
        .BITE_CYCLES (BITE_CYCLES)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .gate    (gate),
        .sel     (sel_q),
        .state_o (state)
    );

    assign wd_armed = (state == WD_RUN);
    assign wd_reset = (state == WD_BITE);

    assert_bite_from_run_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(wd_reset) |-> $past(wd_armed));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        dur_rdata[7:SEL_W] == '0);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!wd_armed && !wd_reset && dur_rdata == 8'h00));

endmodule

// File: tb/pm_watchdog_tb_top.sv
`timescale 1ns/1ps
module pm_watchdog_tb_top;

    localparam int TB_BASE = 6;
    localparam int TB_BITE = 96;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dur_wr = 1'b0;
    logic [7:0] dur_wdata = 8'h00;
    logic [7:0] dur_rdata;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_wdata = 8'h00;
    logic       pd_mode = 1'b0;
    logic       idle_mode = 1'b0;
    logic       wake_n = 1'b1;
    logic       wd_armed;
    logic       wd_reset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pm_watchdog #(.TAP_BASE(TB_BASE), .BITE_CYCLES(TB_BITE)) dut_i (
        .clk(clk), .rst(rst), .dur_wr(dur_wr), .dur_wdata(dur_wdata),
        .dur_rdata(dur_rdata), .svc_wr(svc_wr), .svc_wdata(svc_wdata),
        .pd_mode(pd_mode), .idle_mode(idle_mode), .wake_n(wake_n),
        .wd_armed(wd_armed), .wd_reset(wd_reset)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
    endtask

    task automatic key(logic [7:0] v);
        svc_wr = 1'b1; svc_wdata = v;
        step(1);
        svc_wr = 1'b0;
    endtask

    task automatic service();
        key(8'h1E);
        key(8'hE1);
    endtask

    task automatic set_code(logic [7:0] v);
        dur_wr = 1'b1; dur_wdata = v;
        step(1);
        dur_wr = 1'b0;
    endtask

    // rem = counting edges left until wd_reset rises, seen from this negedge
    task automatic expect_bite(int rem, string req);
        step(rem - 1);
        chk({req, " before tap"}, 32'(wd_reset), 32'd0);
        step(1);
        chk({req, " at tap"}, 32'(wd_reset), 32'd1);
    endtask

    task automatic t_reset_state();
        hw_reset();
        chk("R1 rdata", 32'(dur_rdata), 32'h00);
        chk("R1 armed", 32'(wd_armed), 32'd0);
        chk("R1 reset", 32'(wd_reset), 32'd0);
    endtask

    task automatic t_code_reg();
        hw_reset();
        set_code(8'hFA);
        chk("R2 readback", 32'(dur_rdata), 32'h02);
        set_code(8'h05);
        chk("R2 readback", 32'(dur_rdata), 32'h05);
    endtask

    task automatic t_timeout_code0();
        hw_reset();
        service();
        chk("R4 armed", 32'(wd_armed), 32'd1);
        expect_bite(1 << TB_BASE, "R3 code0");
    endtask

    task automatic t_timeout_code2();
        hw_reset();
        set_code(8'h02);
        service();
        expect_bite(1 << (TB_BASE + 2), "R3 code2");
    endtask

    task automatic t_gap_and_restart();
        hw_reset();
        key(8'h1E);
        step(3);
        key(8'hE1);
        chk("R4 gap arms", 32'(wd_armed), 32'd1);
        step(40);
        service();
        expect_bite(1 << TB_BASE, "R4 restart");
    endtask

    task automatic t_abort();
        hw_reset();
        key(8'hE1);
        chk("R5 lone key", 32'(wd_armed), 32'd0);
        key(8'h1E); key(8'h55); key(8'hE1);
        chk("R5 aborted", 32'(wd_armed), 32'd0);
        service();
        step(20);
        key(8'h1E); key(8'h55); key(8'hE1);
        expect_bite((1 << TB_BASE) - 23, "R5 running");
    endtask

    task automatic t_bite_len();
        hw_reset();
        service();
        expect_bite(1 << TB_BASE, "R6 rise");
        step(10);
        service();
        step(TB_BITE - 13);
        chk("R12 pulse kept", 32'(wd_reset), 32'd1);
        step(1);
        chk("R6 pulse end", 32'(wd_reset), 32'd0);
        chk("R6 disarmed", 32'(wd_armed), 32'd0);
        step(1 << TB_BASE);
        chk("R6 stays off", 32'(wd_reset), 32'd0);
    endtask

    task automatic t_no_sw_off();
        hw_reset();
        service();
        key(8'h00); key(8'hFF); key(8'h1E); key(8'h00);
        set_code(8'h00);
        chk("R7 still armed", 32'(wd_armed), 32'd1);
        hw_reset();
        chk("R7 rst clears", 32'(wd_armed), 32'd0);
    endtask

    task automatic t_pd_freeze();
        hw_reset();
        service();
        step(10);
        pd_mode = 1'b1;
        step(200);
        chk("R8 no bite in pd", 32'(wd_reset), 32'd0);
        pd_mode = 1'b0;
        expect_bite((1 << TB_BASE) - 10, "R8 resume");
    endtask

    task automatic t_idle();
        hw_reset();
        idle_mode = 1'b1;
        service();
        expect_bite(1 << TB_BASE, "R9 idle");
        idle_mode = 1'b0;
    endtask

    task automatic t_wake_hold();
        hw_reset();
        service();
        step(5);
        wake_n = 1'b0;
        pd_mode = 1'b1;
        step(7);
        pd_mode = 1'b0;
        step(90);
        chk("R10 held low", 32'(wd_reset), 32'd0);
        wake_n = 1'b1;
        expect_bite((1 << TB_BASE) - 5, "R10 release");
    endtask

    task automatic t_pd_reset();
        hw_reset();
        service();
        wake_n = 1'b0;
        pd_mode = 1'b1;
        step(5);
        hw_reset();
        pd_mode = 1'b0;
        chk("R11 disarmed", 32'(wd_armed), 32'd0);
        step(20);
        wake_n = 1'b1;
        step((1 << TB_BASE) + 20);
        chk("R11 no bite", 32'(wd_reset), 32'd0);
        service();
        expect_bite(1 << TB_BASE, "R11 hold cleared");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_code_reg();
        t_timeout_code0();
        t_timeout_code2();
        t_gap_and_restart();
        t_abort();
        t_bite_len();
        t_no_sw_off();
        t_pd_freeze();
        t_idle();
        t_wake_hold();
        t_pd_reset();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule